// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the eight status bits of a small processor core: the arithmetic flags (half carry, sign, overflow, negative, zero, carry), a one-bit scratch flag used to move single bits between register operands, and the global interrupt enable. The ALU presents per-flag values with individual load strobes. The sequencer presents interrupt-accept, return-from-interrupt, set-enable and clear-enable strobes, bit-store and bit-load requests with a 3-bit bit index, and a whole-register write.

The sign flag is never stored from outside. It is always derived from the stored negative and overflow flags. The block gates the core's pending interrupt request with the global enable. It also offers the register operand with one bit overwritten by the scratch flag, which serves as the bit-load result.

Top module: `flag_status_reg`

## Requirements
- R1: After reset `statusOut` is 0x00. The bit positions are: 7 interrupt enable (I), 6 scratch (T), 5 half carry (H), 4 sign (S), 3 overflow (V), 2 negative (N), 1 zero (Z), 0 carry (C).
- R2: `flagWe` and `flagIn` use this order: [4]=H, [3]=V, [2]=N, [1]=Z, [0]=C. On a clock edge, each flag whose `flagWe` bit is 1 takes its `flagIn` bit. A flag whose strobe is 0 keeps its value. H is the carry out of bit 3 of the ALU result, as computed by the ALU.
- R3: `statusOut[4]` always equals `statusOut[2] ^ statusOut[3]`.
- R4: `irqAccept` clears I at the next edge, whatever any other input does in that cycle.
- R5: When `irqAccept` and `fullWe` are both 0, `clrIrq` clears I. Otherwise, `retIrq` or `setIrq` sets I. If `clrIrq` and a set request arrive together, the clear wins.
- R6: `irqGated` equals I AND `irqPending` in the same cycle. It is 0 whenever I is 0.
- R7: When `bitStore` is 1 and `fullWe` is 0, T takes `regOperand[bitIdx]` at the next edge.
- R8: `loadResult` is combinational. It equals `regOperand` with bit `bitIdx` replaced by the current T. All other bits pass through unchanged.
- R9: `fullWe` loads bits 7, 6, 5, 3, 2, 1 and 0 from `fullData`. S is then recomputed from the new N and V. This write overrides the flag strobes, `bitStore`, `setIrq`, `retIrq` and `clrIrq`, but not `irqAccept`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flagWe | input | 5 | Per-flag load strobes {H,V,N,Z,C} |
| flagIn | input | 5 | Per-flag values {H,V,N,Z,C} |
| irqAccept | input | 1 | Interrupt taken this cycle |
| retIrq | input | 1 | Return-from-interrupt executed |
| setIrq | input | 1 | Set global interrupt enable |
| clrIrq | input | 1 | Clear global interrupt enable |
| bitStore | input | 1 | Copy an operand bit into T |
| bitIdx | input | 3 | Bit index for store and load |
| regOperand | input | 8 | Register operand |
| fullWe | input | 1 | Whole-register write |
| fullData | input | 8 | Whole-register write data |
| irqPending | input | 1 | Incoming interrupt request |
| statusOut | output | 8 | Current register value |
| irqGated | output | 1 | Request gated by I |
| loadResult | output | 8 | Operand with bit `bitIdx` replaced by T |

## Verification
The bench sweeps every combination of the five flag strobes against many value patterns. It would catch a flag that updates without its strobe, or a sign bit that goes stale after only N or V changes.

It applies all sixteen combinations of accept, return, set and clear, starting from both states of I. A design with the wrong priority would leave interrupts enabled after an accept, or would let a set beat a clear.

Every bit index is exercised for the store and load paths, so an off-by-one index or a leaking neighbour bit shows up directly in T or in `loadResult`. Finally, all 256 whole-register values are written while every other strobe is also active. This exposes a stored S, or a strobe that wrongly beats the full write.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FLAG_W   = 8;
  localparam int ARITH_N  = 5;
  localparam int IDX_W    = $clog2(FLAG_W);
  localparam int POS_I    = 7;
  localparam int POS_T    = 6;
  localparam int POS_H    = 5;
  localparam int POS_S    = 4;
  localparam int POS_V    = 3;
  localparam int POS_N    = 2;
  localparam int POS_Z    = 1;
  localparam int POS_C    = 0;

  typedef struct packed {
    logic                fullLoad;
    logic [ARITH_N-1:0]  arithLoad;
    logic                tLoad;
    logic                iSet;
    logic                iClr;
  } flagStrobe_t;

  function automatic int arithPos(input int i);
    return (i == ARITH_N - 1) ? POS_H : i;
  endfunction
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic [ARITH_N-1:0] flagWe,
  input  logic               fullWe,
  input  logic               bitStore,
  input  logic               irqAccept,
  input  logic               retIrq,
  input  logic               setIrq,
  input  logic               clrIrq,
  output flagStrobe_t        strobes
);
  logic enableReq;

  always_comb begin
    enableReq          = setIrq | retIrq;
    strobes.fullLoad   = fullWe;
    strobes.arithLoad  = fullWe ? '0 : flagWe;
    strobes.tLoad      = bitStore & ~fullWe;
    strobes.iClr       = irqAccept | (~fullWe & clrIrq);
    strobes.iSet       = ~irqAccept & ~fullWe & ~clrIrq & enableReq;
  end
endmodule

// File: rtl/flag_dpath.sv
module flag_dpath
  import flag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  flagStrobe_t        strobes,
  input  logic [ARITH_N-1:0] flagIn,
  input  logic [FLAG_W-1:0]  fullData,
  input  logic [IDX_W-1:0]   bitIdx,
  input  logic [FLAG_W-1:0]  regOperand,
  output logic [FLAG_W-1:0]  statusOut,
  output logic [FLAG_W-1:0]  loadResult
);
  logic               iQ;
  logic               tQ;
  logic [ARITH_N-1:0] arithQ;
  logic               selBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               iQ <= 1'b0;
    else if (strobes.iClr)   iQ <= 1'b0;
    else if (strobes.iSet)   iQ <= 1'b1;
    else if (strobes.fullLoad) iQ <= fullData[POS_I];
  end

  always_comb selBit = regOperand[bitIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tQ <= 1'b0;
    else if (strobes.fullLoad) tQ <= fullData[POS_T];
    else if (strobes.tLoad)    tQ <= selBit;
  end

  for (genvar g = 0; g < ARITH_N; g++) begin : g_arith
    localparam int P = arithPos(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    arithQ[g] <= 1'b0;
      else if (strobes.fullLoad)    arithQ[g] <= fullData[P];
      else if (strobes.arithLoad[g]) arithQ[g] <= flagIn[g];
    end
  end

  always_comb begin
    statusOut        = '0;
    statusOut[POS_I] = iQ;
    statusOut[POS_T] = tQ;
    statusOut[POS_H] = arithQ[ARITH_N-1];
    statusOut[POS_V] = arithQ[POS_V];
    statusOut[POS_N] = arithQ[POS_N];
    statusOut[POS_Z] = arithQ[POS_Z];
    statusOut[POS_C] = arithQ[POS_C];
    statusOut[POS_S] = arithQ[POS_N] ^ arithQ[POS_V];
  end

  for (genvar b = 0; b < FLAG_W; b++) begin : g_load
    always_comb loadResult[b] = (bitIdx == IDX_W'(b)) ? tQ : regOperand[b];
  end
endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
  import flag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] flagWe,
  input  logic [4:0] flagIn,
  input  logic       irqAccept,
  input  logic       retIrq,
  input  logic       setIrq,
  input  logic       clrIrq,
  input  logic       bitStore,
  input  logic [2:0] bitIdx,
  input  logic [7:0] regOperand,
  input  logic       fullWe,
  input  logic [7:0] fullData,
  input  logic       irqPending,
  output logic [7:0] statusOut,
  output logic       irqGated,
  output logic [7:0] loadResult
);
  flagStrobe_t strobes;

  flag_ctrl ctrl_i (
    .flagWe(flagWe), .fullWe(fullWe), .bitStore(bitStore),
    .irqAccept(irqAccept), .retIrq(retIrq), .setIrq(setIrq),
    .clrIrq(clrIrq), .strobes(strobes)
  );

  flag_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .flagIn(flagIn),
    .fullData(fullData), .bitIdx(bitIdx), .regOperand(regOperand),
    .statusOut(statusOut), .loadResult(loadResult)
  );

  always_comb irqGated = statusOut[POS_I] & irqPending;
endmodule

// File: rtl/flag_status_chk.sv
module flag_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] flagWe,
  input logic       irqAccept,
  input logic       retIrq,
  input logic       setIrq,
  input logic       clrIrq,
  input logic       bitStore,
  input logic [2:0] bitIdx,
  input logic [7:0] regOperand,
  input logic       fullWe,
  input logic       irqPending,
  input logic [7:0] statusOut,
  input logic       irqGated
);
  assert_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[4] == (statusOut[3] ^ statusOut[2]));

  assert_accept_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqAccept |=> !statusOut[7]);

  assert_set_path_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!irqAccept && !fullWe && !clrIrq && (retIrq || setIrq)) |=> statusOut[7]);

  assert_clear_path_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!fullWe && clrIrq) |=> !statusOut[7]);

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !statusOut[7] |-> !irqGated);

  assert_store_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bitStore && !fullWe) |=> statusOut[6] == (($past(regOperand) >> $past(bitIdx)) & 8'h01) != 8'h00);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe == 5'b0 && !fullWe && !bitStore && !irqAccept && !retIrq && !setIrq && !clrIrq)
      |=> $stable(statusOut));
endmodule

bind flag_status_reg flag_status_chk chk_i (
  .clk(clk), .rstN(rstN), .flagWe(flagWe), .irqAccept(irqAccept),
  .retIrq(retIrq), .setIrq(setIrq), .clrIrq(clrIrq), .bitStore(bitStore),
  .bitIdx(bitIdx), .regOperand(regOperand), .fullWe(fullWe),
  .irqPending(irqPending), .statusOut(statusOut), .irqGated(irqGated)
);

// File: tb/flag_status_reg_tb.sv
module flag_status_reg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] flagWe = '0, flagIn = '0;
  logic       irqAccept = 0, retIrq = 0, setIrq = 0, clrIrq = 0, bitStore = 0;
  logic [2:0] bitIdx = '0;
  logic [7:0] regOperand = '0;
  logic       fullWe = 0;
  logic [7:0] fullData = '0;
  logic       irqPending = 0;
  logic [7:0] statusOut, loadResult;
  logic       irqGated;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model = '0;

  always #2 clk = ~clk;

  flag_status_reg dut_i (.*);

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] we, input logic [4:0] fin,
                      input logic acc, input logic ret, input logic se, input logic cl,
                      input logic bs, input logic [2:0] idx, input logic [7:0] op,
                      input logic fw, input logic [7:0] fd, input logic pend,
                      input string tag);
    logic [7:0] n, lr;
    flagWe = we; flagIn = fin; irqAccept = acc; retIrq = ret; setIrq = se;
    clrIrq = cl; bitStore = bs; bitIdx = idx; regOperand = op; fullWe = fw;
    fullData = fd; irqPending = pend;
    #1;
    lr = op; lr[idx] = model[6];
    check(loadResult, lr, "R8");
    check({7'b0, irqGated}, {7'b0, model[7] & pend}, "R6");
    n = model;
    if (fw) n = fd;
    else begin
      if (we[4]) n[5] = fin[4];
      if (we[3]) n[3] = fin[3];
      if (we[2]) n[2] = fin[2];
      if (we[1]) n[1] = fin[1];
      if (we[0]) n[0] = fin[0];
      if (bs) n[6] = op[idx];
      if (cl) n[7] = 1'b0;
      else if (se | ret) n[7] = 1'b1;
    end
    if (acc) n[7] = 1'b0;
    n[4] = n[3] ^ n[2];
    @(posedge clk); @(negedge clk);
    model = n;
    check(statusOut, n, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(statusOut, 8'h00, "R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    check(statusOut, 8'h00, "R1 after release");

    // R2 R3: every strobe mask against varied values
    for (int w = 0; w < 32; w++)
      for (int k = 0; k < 8; k++)
        step(5'(w), 5'((w * 7 + k * 13 + k * k) & 31), 0, 0, 0, 0, 0, 3'(k), 8'(w * k),
             0, 8'h00, 0, "R2 R3 flag update");

    // R4 R5 R6: all interrupt-strobe combinations from both I states
    for (int m = 0; m < 32; m++) begin
      step(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 1, {m[4], 7'h00}, m[0], "R9 preset");
      step(0, 0, m[3], m[2], m[1], m[0], 0, 0, 8'h00, 0, 8'h00, m[1], "R4 R5 enable control");
      step(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, 1, "R6 gate");
    end

    // R7 R8: every index with several operands
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 4; p++) begin
        logic [7:0] op;
        op = (p == 0) ? 8'hA5 : (p == 1) ? 8'h5A : (p == 2) ? (8'h01 << i) : ~(8'h01 << i);
        step(0, 0, 0, 0, 0, 0, 1, 3'(i), op, 0, 8'h00, 0, "R7 bit store");
        step(0, 0, 0, 0, 0, 0, 0, 3'(i), ~op, 0, 8'h00, 0, "R8 bit load");
        step(0, 0, 0, 0, 0, 0, 0, 3'(7 - i), op, 0, 8'h00, 0, "R8 bit load");
      end

    // R9: whole-register write against competing strobes
    for (int d = 0; d < 256; d++)
      step(5'h1F, ~5'(d), (d % 5) == 0, d[2], d[0], d[1], 1, 3'(d), ~8'(d),
           1, 8'(d), d[3], "R9 R3 full write");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %h expected %h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule